// File: doc/BRIEF.md
# Oversampled Manchester Line Decoder

This block turns a single Manchester-coded serial line into a plain NRZ level, a capture strobe and a bit-rate clock. A local clock that runs at a fixed multiple of the nominal bit rate samples the line. The line passes through a synchroniser, and a transition detector looks for level changes. Each accepted transition opens a timing window. The window length is three quarters of a nominal bit period, counted in local clock cycles. When the window closes, the synchronised line level is stored as the new NRZ value and a one-cycle strobe is raised. Any transition that falls inside the window is discarded, so the edges at bit boundaries never start a window. The detector therefore stays locked to the mid-bit transitions without any phase tracking loop.

The capture point does not need to be exact, so one fixed window covers a band of line rates around the nominal one. The oversampling ratio is an elaboration parameter. The window length is derived from it as `3*OVERSAMPLE/4`: 12 cycles at 16x and 6 cycles at 8x. The recovered clock is the synchronised line XOR the stored NRZ level. Its rising edges follow the bit timing, but the duty cycle of individual pulses can vary.

Top module: `mdec_top`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted, and on the cycle after it, `nrzOut` and `dataValid` are 0. After release, no strobe appears until the line changes level.
- R2: Counting from the third cycle after reset, `recClk` equals the value `lineIn` had two rising edges earlier, XOR the current `nrzOut`.
- R3: Let DELAY be `3*OVERSAMPLE/4` (12 at the default 16x). A transition that starts a window is first sampled on some rising edge. `dataValid` is high for exactly one cycle, beginning DELAY+2 rising edges after that edge.
- R4: The value stored in `nrzOut` at a capture is the `lineIn` level sampled DELAY rising edges after the edge that first sampled the starting transition.
- R5: A transition reaches the edge detector in some cycle. If a window is open in that cycle, including the cycle in which that window closes, the transition is ignored. The first transition after the window closes starts a new window.
- R6: `nrzOut` changes only on the cycle in which `dataValid` is high. It holds its value between captures.
- R7: Line coding is as follows: bit b occupies the first half of its period at level b and the second half at level not-b. The first half is floor(P/2) clocks long. Consider a frame that starts from an idle-low line, whose first bit is 0, and whose bit period P is any value from 13 to 19 clocks. The strobes then deliver the frame's 2nd to last bits in order. One further capture follows, with value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVERSAMPLE times the nominal bit rate |
| rst | input | 1 | Synchronous active-high reset |
| lineIn | input | 1 | Manchester-coded serial line, asynchronous to clk |
| nrzOut | output | 1 | Recovered NRZ level, updated at each capture |
| recClk | output | 1 | Recovered bit clock: synchronised line XOR nrzOut |
| dataValid | output | 1 | One-cycle strobe marking a new value on nrzOut |

## Verification
The checker tests these properties on every cycle:
- the reset clearing;
- the two-stage relation between the line and `recClk`;
- the single-cycle width of the strobe;
- the hold of the NRZ level between strobes;
- the minimum spacing of DELAY+1 cycles between strobes, which follows from ignoring edges while a window is open.

Only the bench scenarios can show the exact capture cycle and the captured value. The same is true of correct lock across the band of bit periods and all data patterns. So is the case where an edge falls in the very cycle a window closes, and the case where a reset lands in the middle of an open window.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Strobes sent from the timing control to the datapath
  typedef struct packed {
    logic capture;   // window expired: store the synchronised line level
  } mdecStrobesT;

endpackage

// File: rtl/mdec_control.sv
module mdec_control
  import mdec_pkg::*;
#(
  parameter int DELAY = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lineEdge,
  output mdecStrobesT strobes
);

  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY - 1);

  logic             windowOpen;
  logic [CNT_W-1:0] windowCnt;
  logic             windowDone;

  // The window closes in the cycle where the count has reached zero
  assign windowDone = windowOpen && (windowCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      windowOpen <= 1'b0;
      windowCnt  <= '0;
    end else if (!windowOpen) begin
      if (lineEdge) begin
        windowOpen <= 1'b1;
        windowCnt  <= CNT_LOAD;
      end
    end else if (windowDone) begin
      // Edges that arrive in the closing cycle are dropped as well
      windowOpen <= 1'b0;
    end else begin
      windowCnt <= windowCnt - 1'b1;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.capture = windowDone;
  end

endmodule

// File: rtl/mdec_datapath.sv
module mdec_datapath
  import mdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lineIn,
  input  mdecStrobesT strobes,
  output logic        lineEdge,
  output logic        nrzOut,
  output logic        recClk,
  output logic        dataValid
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineSync;
  logic                   linePrev;
  logic                   nrzQ;
  logic                   validQ;

  // Synchroniser chain for the asynchronous line
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gen_sync
    if (g == 0) begin : gen_first
      always_ff @(posedge clk) begin
        if (rst) syncQ[0] <= 1'b0;
        else     syncQ[0] <= lineIn;
      end
    end else begin : gen_next
      always_ff @(posedge clk) begin
        if (rst) syncQ[g] <= 1'b0;
        else     syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign lineSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) linePrev <= 1'b0;
    else     linePrev <= lineSync;
  end

  assign lineEdge = lineSync ^ linePrev;

  // Capture register and its strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      nrzQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.capture;
      if (strobes.capture) nrzQ <= lineSync;
    end
  end

  assign nrzOut    = nrzQ;
  assign dataValid = validQ;
  assign recClk    = lineSync ^ nrzQ;

endmodule

// File: rtl/mdec_top.sv
module mdec_top
  import mdec_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic nrzOut,
  output logic recClk,
  output logic dataValid
);

  localparam int DELAY = (3 * OVERSAMPLE) / 4;

  mdecStrobesT strobes;
  logic        lineEdge;

  mdec_control #(
    .DELAY(DELAY)
  ) u_control (
    .clk     (clk),
    .rst     (rst),
    .lineEdge(lineEdge),
    .strobes (strobes)
  );

  mdec_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .lineIn   (lineIn),
    .strobes  (strobes),
    .lineEdge (lineEdge),
    .nrzOut   (nrzOut),
    .recClk   (recClk),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
  parameter int OVERSAMPLE = 16
) (
  input logic clk,
  input logic rst,
  input logic lineIn,
  input logic nrzOut,
  input logic recClk,
  input logic dataValid
);

  localparam int DELAY = (3 * OVERSAMPLE) / 4;
  localparam int GAP_W = $clog2(DELAY + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DELAY + 1);

  logic [1:0]       liveCycles;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      liveCycles <= '0;
      gapCnt     <= GAP_MAX;
    end else begin
      if (liveCycles != 2'd3) liveCycles <= liveCycles + 1'b1;
      if (dataValid)            gapCnt <= '0;
      else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!dataValid && !nrzOut)); // R1

  AST_RECCLK_RELATION: assert property (@(posedge clk) disable iff (rst)
    (liveCycles >= 2'd2) |-> (recClk == ($past(lineIn, 2) ^ nrzOut))); // R2

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid); // R3

  AST_WINDOW_SPACING: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> (gapCnt >= GAP_W'(DELAY))); // R5

  AST_NRZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((liveCycles >= 2'd1) && !dataValid) |-> $stable(nrzOut)); // R6

endmodule

bind mdec_top mdec_checker #(
  .OVERSAMPLE(OVERSAMPLE)
) u_mdec_checker (
  .clk      (clk),
  .rst      (rst),
  .lineIn   (lineIn),
  .nrzOut   (nrzOut),
  .recClk   (recClk),
  .dataValid(dataValid)
);

// File: tb/mdec_top_bench.sv
module mdec_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OVERSAMPLE = 16;
  localparam int DELAY      = (3 * OVERSAMPLE) / 4;
  localparam int NBITS      = 7;
  localparam int GAP        = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineIn = 1'b0;
  logic nrzOut, recClk, dataValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic heldNrz = 1'b0;
  logic l1 = 1'b0;
  logic l2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdec_top #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(2)) u_mdec_top (
    .clk(clk), .rst(rst), .lineIn(lineIn),
    .nrzOut(nrzOut), .recClk(recClk), .dataValid(dataValid)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One cycle: check outputs at the falling edge, then drive the next line level
  task automatic tick(input logic nxt, input logic expV, input logic expN,
                      input string tagV, input string tagN);
    @(negedge clk);
    check(dataValid === expV, tagV, dataValid, expV);
    if (expV) begin
      heldNrz = expN;
      check(nrzOut === heldNrz, tagN, nrzOut, heldNrz);
    end else begin
      check(nrzOut === heldNrz, "R6", nrzOut, heldNrz);
    end
    check(recClk === (l2 ^ heldNrz), "R2", recClk, l2 ^ heldNrz);
    lineIn = nxt;
    l2 = l1;
    l1 = nxt;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    lineIn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(dataValid === 1'b0, "R1", dataValid, 1'b0);
        check(nrzOut === 1'b0, "R1", nrzOut, 1'b0);
      end
    end
    rst = 1'b0;
    // R1: no strobe without a transition
    for (int k = 0; k < 30; k++) tick(1'b0, 1'b0, 1'b0, "R1", "R1");

    // R5: second edge lands in the closing cycle of the window -> ignored
    for (int k = 0; k < 50; k++)
      tick((k >= 1 && k < 13), (k == 16), 1'b0, "R5", "R4");

    // R5: second edge one cycle after closing -> restarts the window
    for (int k = 0; k < 50; k++) begin
      logic ev, en;
      ev = (k == 16) || (k == 29);
      en = (k == 16) ? 1'b1 : 1'b0;
      tick((k >= 1 && k < 14), ev, en, "R5", "R4");
    end

    // R1: reset in the middle of an open window cancels the capture
    for (int k = 0; k < 6; k++) tick((k >= 1), 1'b0, 1'b0, "R1", "R1");
    @(negedge clk);
    rst = 1'b1;
    lineIn = 1'b0;
    l1 = 1'b0;
    l2 = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    heldNrz = 1'b0;
    for (int k = 0; k < 30; k++) tick(1'b0, 1'b0, 1'b0, "R1", "R1");

    // R7 / R3: sweep of bit periods and every data pattern
    for (int p = 13; p <= 19; p++) begin
      for (int pat = 0; pat < 64; pat++) begin
        logic [NBITS-1:0] bits;
        int h;
        h = p / 2;
        bits = {pat[5:0], 1'b0};
        for (int k = 0; k < NBITS * p + GAP; k++) begin
          logic lv, ev, en;
          int off, j;
          if (k < NBITS * p) begin
            lv = ((k % p) < h) ? bits[k / p] : ~bits[k / p];
          end else begin
            lv = 1'b0;
          end
          off = k - h - 3 - DELAY;
          ev = 1'b0;
          en = 1'b0;
          if (off >= 0 && (off % p) == 0) begin
            j = off / p;
            if (j < NBITS) begin
              ev = 1'b1;
              en = (j + 1 < NBITS) ? bits[j + 1] : 1'b0;
            end
          end
          tick(lv, ev, en, "R3", "R7");
        end
      end
    end

    summary();
  end

endmodule